// File: doc/BRIEF.md
# Bit-Plane Coding Pass Scanner

This block walks a square code block of sign-magnitude coefficients one bit-plane at a time, starting at the top magnitude bit and ending at bit 0. Each bit-plane is split into three passes that always run in the same order: a propagation pass, a refinement pass and a clean-up pass. Every coded bit leaves the block as one (context, decision) pair on a valid/ready stream, ready to be fed to an entropy coder. The arithmetic coder itself is not part of this block. The context label used here is a reduced one, not the full standard table.

Coefficients are written into the block's own array through a load port while the block is idle. A start pulse then launches the scan. The block keeps three state bits for each sample: significant, already refined, and coded in the current plane. It does not step through every sample three times per plane. Instead it tests the four samples of a stripe column at once and only spends a cycle on samples that belong to the current pass. When a whole group of four columns holds nothing for the current pass, it jumps over the group in a single cycle. A level `done` flag marks the end of the block.

Top module: `bpc_pass_scanner`

## Requirements
- R1: After reset, `out_valid` and `done` are both low.
- R2: The stream order is as follows. Bit-planes go from 7 down to 0. Within a plane the passes run propagation (`out_pass`=0), refinement (1), then clean-up (2). Each pass visits the four-row stripes from top to bottom, the columns of a stripe from left to right, and the rows of a column from top to bottom.
- R3: Pass membership is decided per sample. Propagation takes a sample that is not yet significant and has at least one significant sample among its eight neighbours. Refinement takes a sample that was significant before the current plane. Clean-up takes every sample not yet coded in the plane. So each plane yields exactly 256 decision pairs, and no sample is coded twice in one plane.
- R4: Decision pairs carry these contexts. In propagation and clean-up, `out_ctx` is the number of significant neighbours (0 to 8), using the state as updated by all earlier pairs. In refinement, `out_ctx` is 10 on the first refinement of a sample and 11 after that. The decision bit is the magnitude bit of the current plane.
- R5: When a propagation or clean-up decision is 1, the sample becomes significant. The very next pair then has `out_ctx`=9 and carries the sign input (1 means negative). There is exactly one such sign pair for each non-zero coefficient.
- R6: While `out_valid` is high and `out_ready` is low, the scanner holds its position, and `out_ctx`, `out_bit` and `out_pass` stay unchanged.
- R7: `done` rises after the last pair has been accepted. While `done` is high, `out_valid` is low, and `done` stays high until the next start. A start pulse during a scan has no effect.
- R8: The scan skips empty work. With `out_ready` held high, an all-zero block reaches `done` within 2830 cycles of start. That figure allows one cycle per empty column in clean-up and one cycle per empty four-column group in the other two passes.
- R9: A sample at row y and column x (both 0 to 15) is loaded at `ld_idx` = y*16 + x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Write one coefficient into the array |
| ld_idx | input | 8 | Sample index, row*16 + column |
| ld_mag | input | 8 | Coefficient magnitude |
| ld_sign | input | 1 | Coefficient sign, 1 = negative |
| start | input | 1 | Launch a scan when idle |
| out_valid | output | 1 | A pair is offered |
| out_ready | input | 1 | Consumer accepts the pair |
| out_ctx | output | 4 | Context label |
| out_bit | output | 1 | Decision bit |
| out_pass | output | 2 | Pass of the pair: 0 propagation, 1 refinement, 2 clean-up |
| done | output | 1 | Scan finished; held until the next start |

## Verification
The hardest case to reach is a sample that becomes significant in the middle of a column. That event changes the neighbour count and the pass membership of samples that are scanned a few cycles later. The same thing happens in the next column and in the stripe below, and it can happen while the consumer is stalling. Blocks that are dense, sparse, checkerboard-shaped or hold a single non-zero sample drive the scanner into these chains. The ready line is dropped at random during each of these blocks. The whole pair stream is then compared against a bench model that scans sample by sample.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  typedef enum logic [1:0] {
    PASS_SP = 2'd0,
    PASS_MR = 2'd1,
    PASS_CU = 2'd2
  } pass_e;

  localparam logic [3:0] CTX_SIGN     = 4'd9;
  localparam logic [3:0] CTX_MR_FIRST = 4'd10;
  localparam logic [3:0] CTX_MR_LATER = 4'd11;
endpackage

// File: rtl/bpc_coef_mem.sv
module bpc_coef_mem #(
  parameter int N     = 256,
  parameter int MAG_W = 8,
  localparam int IW   = $clog2(N),
  localparam int PW   = $clog2(MAG_W)
) (
  input  logic          clk,
  input  logic          ld_en,
  input  logic [IW-1:0] ld_idx,
  input  logic [MAG_W-1:0] ld_mag,
  input  logic          ld_sign,
  input  logic [PW-1:0] plane,
  output logic [N-1:0]  bit_vec,
  output logic [N-1:0]  sign_vec
);
  logic [MAG_W-1:0] mag_q [N];
  logic [N-1:0]     sign_q;

  always_ff @(posedge clk) begin
    if (ld_en) begin
      mag_q[ld_idx]  <= ld_mag;
      sign_q[ld_idx] <= ld_sign;
    end
  end

  // slice the current plane out of every magnitude
  always_comb begin
    for (int i = 0; i < N; i++) bit_vec[i] = mag_q[i][plane];
  end
  assign sign_vec = sign_q;
endmodule

// File: rtl/bpc_state.sv
module bpc_state #(
  parameter int N  = 256,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_all,
  input  logic          clr_vis,
  input  logic          upd_en,
  input  logic [IW-1:0] upd_idx,
  input  logic          upd_sig,
  input  logic          upd_ref,
  output logic [N-1:0]  sig_vec,
  output logic [N-1:0]  vis_vec,
  output logic [N-1:0]  ref_vec
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr_all) begin
      sig_vec <= '0;
      vis_vec <= '0;
      ref_vec <= '0;
    end else begin
      if (clr_vis) vis_vec <= '0;
      if (upd_en) begin
        vis_vec[upd_idx] <= 1'b1;
        if (upd_sig) sig_vec[upd_idx] <= 1'b1;
        if (upd_ref) ref_vec[upd_idx] <= 1'b1;
      end
    end
  end

  // R3: the scan never codes a sample twice within one plane
  p_code_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> !vis_vec[upd_idx]);
endmodule

// File: rtl/bpc_elig.sv
module bpc_elig import bpc_pkg::*; #(
  parameter int BLK      = 16,
  parameter int STRIPE_H = 4,
  parameter int GRP_W    = 4,
  localparam int N  = BLK * BLK,
  localparam int IW = $clog2(N),
  localparam int CW = $clog2(BLK) + 1,
  localparam int RW = $clog2(STRIPE_H + 1),
  localparam int SW = $clog2(BLK / STRIPE_H)
) (
  input  logic [N-1:0]  sig_vec,
  input  logic [N-1:0]  vis_vec,
  input  pass_e         pass,
  input  logic [SW-1:0] stripe,
  input  logic [CW-1:0] col,
  input  logic [RW-1:0] row_from,
  output logic          col_hit,
  output logic [RW-1:0] hit_row,
  output logic          grp_empty,
  output logic [3:0]    nbr_cnt,
  output logic [IW-1:0] hit_idx
);
  function automatic logic [3:0] count_nbrs(input logic [N-1:0] s, input int x, input int y);
    logic [3:0] n;
    n = '0;
    for (int dy = -1; dy <= 1; dy++)
      for (int dx = -1; dx <= 1; dx++)
        if (!(dx == 0 && dy == 0) && x + dx >= 0 && x + dx < BLK &&
            y + dy >= 0 && y + dy < BLK)
          n = n + 4'(s[(y + dy) * BLK + x + dx]);
    return n;
  endfunction

  function automatic logic in_pass(input pass_e p, input logic [N-1:0] s,
                                   input logic [N-1:0] v, input int x, input int y);
    int i;
    i = y * BLK + x;
    case (p)
      PASS_SP: return !s[i] && (count_nbrs(s, x, y) != 4'd0);
      PASS_MR: return s[i] && !v[i];
      default: return !v[i];
    endcase
  endfunction

  int base_y;
  assign base_y = int'(stripe) * STRIPE_H;

  always_comb begin
    col_hit = 1'b0;
    hit_row = '0;
    // scan upward so the topmost eligible row wins
    for (int r = STRIPE_H - 1; r >= 0; r--) begin
      if (r >= int'(row_from) && in_pass(pass, sig_vec, vis_vec, int'(col), base_y + r)) begin
        col_hit = 1'b1;
        hit_row = RW'(r);
      end
    end
    grp_empty = 1'b1;
    for (int g = 0; g < GRP_W; g++)
      for (int r = 0; r < STRIPE_H; r++)
        if (int'(col) + g < BLK && in_pass(pass, sig_vec, vis_vec, int'(col) + g, base_y + r))
          grp_empty = 1'b0;
    hit_idx = IW'((base_y + int'(hit_row)) * BLK + int'(col));
    nbr_cnt = count_nbrs(sig_vec, int'(col), base_y + int'(hit_row));
  end
endmodule

// File: rtl/bpc_pass_scanner.sv
module bpc_pass_scanner import bpc_pkg::*; #(
  parameter int BLK      = 16,
  parameter int STRIPE_H = 4,
  parameter int GRP_W    = 4,
  parameter int MAG_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ld_en,
  input  logic [$clog2(BLK*BLK)-1:0] ld_idx,
  input  logic [MAG_W-1:0]           ld_mag,
  input  logic                       ld_sign,
  input  logic                       start,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [3:0]                 out_ctx,
  output logic                       out_bit,
  output logic [1:0]                 out_pass,
  output logic                       done
);
  localparam int N       = BLK * BLK;
  localparam int IW      = $clog2(N);
  localparam int CW      = $clog2(BLK) + 1;
  localparam int RW      = $clog2(STRIPE_H + 1);
  localparam int NSTRIPE = BLK / STRIPE_H;
  localparam int SW      = $clog2(NSTRIPE);
  localparam int PW      = $clog2(MAG_W);

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_SIGN} st_e;

  st_e           st_q;
  pass_e         pass_q;
  logic [PW-1:0] plane_q;
  logic [SW-1:0] stripe_q;
  logic [CW-1:0] col_q;
  logic [RW-1:0] row_q;
  logic          done_q, sgn_q;

  logic [N-1:0]  bit_vec, sign_vec, sig_vec, vis_vec, ref_vec;
  logic          col_hit, grp_empty;
  logic [RW-1:0] hit_row;
  logic [3:0]    nbr_cnt;
  logic [IW-1:0] hit_idx;

  // named internal events
  logic          launch, emit_fire, new_sig, advance, skip_grp, col_wrap;
  logic          last_stripe, plane_end, clr_vis;
  logic          cur_bit;
  logic [CW-1:0] step, col_nx;

  bpc_coef_mem #(.N(N), .MAG_W(MAG_W)) u_mem (
    .clk(clk), .ld_en(ld_en), .ld_idx(ld_idx), .ld_mag(ld_mag), .ld_sign(ld_sign),
    .plane(plane_q), .bit_vec(bit_vec), .sign_vec(sign_vec));

  bpc_state #(.N(N)) u_state (
    .clk(clk), .rst_n(rst_n), .clr_all(launch), .clr_vis(clr_vis),
    .upd_en(emit_fire), .upd_idx(hit_idx), .upd_sig(new_sig),
    .upd_ref(pass_q == PASS_MR),
    .sig_vec(sig_vec), .vis_vec(vis_vec), .ref_vec(ref_vec));

  bpc_elig #(.BLK(BLK), .STRIPE_H(STRIPE_H), .GRP_W(GRP_W)) u_elig (
    .sig_vec(sig_vec), .vis_vec(vis_vec), .pass(pass_q), .stripe(stripe_q),
    .col(col_q), .row_from(row_q), .col_hit(col_hit), .hit_row(hit_row),
    .grp_empty(grp_empty), .nbr_cnt(nbr_cnt), .hit_idx(hit_idx));

  assign cur_bit     = bit_vec[hit_idx];
  assign launch      = (st_q == ST_IDLE) && start;
  assign emit_fire   = (st_q == ST_SCAN) && col_hit && out_ready;
  assign new_sig     = emit_fire && (pass_q != PASS_MR) && cur_bit;
  assign advance     = (st_q == ST_SCAN) && !col_hit;
  assign skip_grp    = ((int'(col_q) % GRP_W) == 0) && (row_q == '0) && grp_empty;
  assign step        = skip_grp ? CW'(GRP_W) : CW'(1);
  assign col_nx      = col_q + step;
  assign col_wrap    = col_nx >= CW'(BLK);
  assign last_stripe = stripe_q == SW'(NSTRIPE - 1);
  assign plane_end   = advance && col_wrap && last_stripe && (pass_q == PASS_CU);
  assign clr_vis     = plane_end && (plane_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      pass_q   <= PASS_SP;
      plane_q  <= '0;
      stripe_q <= '0;
      col_q    <= '0;
      row_q    <= '0;
      done_q   <= 1'b0;
      sgn_q    <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          st_q     <= ST_SCAN;
          plane_q  <= PW'(MAG_W - 1);
          pass_q   <= PASS_SP;
          stripe_q <= '0;
          col_q    <= '0;
          row_q    <= '0;
          done_q   <= 1'b0;
        end
        ST_SCAN: begin
          if (emit_fire) begin
            row_q <= hit_row + RW'(1);
            if (new_sig) begin
              sgn_q <= sign_vec[hit_idx];
              st_q  <= ST_SIGN;
            end
          end else if (advance) begin
            row_q <= '0;
            if (!col_wrap) col_q <= col_nx;
            else begin
              col_q <= '0;
              if (!last_stripe) stripe_q <= stripe_q + SW'(1);
              else begin
                stripe_q <= '0;
                case (pass_q)
                  PASS_SP: pass_q <= PASS_MR;
                  PASS_MR: pass_q <= PASS_CU;
                  default: begin
                    pass_q <= PASS_SP;
                    if (plane_q == '0) begin
                      st_q   <= ST_IDLE;
                      done_q <= 1'b1;
                    end else plane_q <= plane_q - PW'(1);
                  end
                endcase
              end
            end
          end
        end
        default: if (out_ready) st_q <= ST_SCAN;
      endcase
    end
  end

  always_comb begin
    out_valid = ((st_q == ST_SCAN) && col_hit) || (st_q == ST_SIGN);
    out_pass  = pass_q;
    if (st_q == ST_SIGN) begin
      out_bit = sgn_q;
      out_ctx = CTX_SIGN;
    end else begin
      out_bit = cur_bit;
      if (pass_q == PASS_MR) out_ctx = ref_vec[hit_idx] ? CTX_MR_LATER : CTX_MR_FIRST;
      else                   out_ctx = nbr_cnt;
    end
  end
  assign done = done_q;

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_ctx) && $stable(out_bit) && $stable(out_pass));
  p_sign_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_ctx != CTX_SIGN && out_pass != PASS_MR && out_bit
    |=> out_valid && out_ctx == CTX_SIGN);
  p_sp_nbr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_pass == PASS_SP && out_ctx != CTX_SIGN |-> out_ctx != 4'd0);
  p_mr_ctx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_pass == PASS_MR |-> out_ctx == CTX_MR_FIRST || out_ctx == CTX_MR_LATER);
  p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);
endmodule

// File: tb/bpc_pass_scanner_test.sv
module bpc_pass_scanner_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_en = 1'b0;
  logic [7:0] ld_idx = '0;
  logic [7:0] ld_mag = '0;
  logic ld_sign = 1'b0;
  logic start = 1'b0;
  logic out_ready = 1'b0;
  logic out_valid, out_bit, done;
  logic [3:0] out_ctx;
  logic [1:0] out_pass;

  int total = 0;
  int bad = 0;

  bit [7:0] mag [256];
  bit       sgn [256];
  bit [255:0] m_sig, m_vis, m_ref;
  logic [6:0] exp_q[$];
  logic [6:0] got_q[$];
  int holds_bad;
  int run_cycles;

  bpc_pass_scanner uut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_mag(ld_mag),
    .ld_sign(ld_sign), .start(start), .out_valid(out_valid), .out_ready(out_ready),
    .out_ctx(out_ctx), .out_bit(out_bit), .out_pass(out_pass), .done(done));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int nbr_sig(input int x, input int y);
    int ox [8] = '{-1, 0, 1, -1, 1, -1, 0, 1};
    int oy [8] = '{-1, -1, -1, 0, 0, 1, 1, 1};
    int n = 0;
    for (int k = 0; k < 8; k++) begin
      int xx = x + ox[k];
      int yy = y + oy[k];
      if (xx >= 0 && xx < 16 && yy >= 0 && yy < 16 && m_sig[yy*16+xx]) n++;
    end
    return n;
  endfunction

  // reference: visit each sample of each pass in scan order
  task automatic build_model();
    exp_q.delete();
    m_sig = '0;
    m_ref = '0;
    for (int p = 7; p >= 0; p--) begin
      m_vis = '0;
      for (int ps = 0; ps < 3; ps++)
        for (int s = 0; s < 4; s++)
          for (int c = 0; c < 16; c++)
            for (int r = 0; r < 4; r++) begin
              int y = s*4 + r;
              int i = y*16 + c;
              bit b = mag[i][p];
              if (ps == 1) begin
                if (m_sig[i] && !m_vis[i]) begin
                  exp_q.push_back({2'd1, m_ref[i] ? 4'd11 : 4'd10, b});
                  m_ref[i] = 1'b1;
                  m_vis[i] = 1'b1;
                end
              end else if ((ps == 0 && !m_sig[i] && nbr_sig(c, y) > 0) || (ps == 2 && !m_vis[i])) begin
                exp_q.push_back({2'(ps), 4'(nbr_sig(c, y)), b});
                m_vis[i] = 1'b1;
                if (b) begin
                  m_sig[i] = 1'b1;
                  exp_q.push_back({2'(ps), 4'd9, sgn[i]});
                end
              end
            end
    end
  endtask

  task automatic load_block();
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      ld_en = 1'b1;
      ld_idx = 8'(i);
      ld_mag = mag[i];
      ld_sign = sgn[i];
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic run_block(input int rdy_pct, input bit mid_start);
    logic [6:0] prev;
    bit prev_stall = 1'b0;
    got_q.delete();
    holds_bad = 0;
    run_cycles = 0;
    prev = '0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!done && run_cycles < 40000) begin
      logic [6:0] o = {out_pass, out_ctx, out_bit};
      bit r = ($urandom % 100) < rdy_pct;
      if (prev_stall && (!out_valid || o != prev)) holds_bad++;
      out_ready = r;
      if (out_valid && r) got_q.push_back(o);
      prev_stall = out_valid && !r;
      prev = o;
      start = (mid_start && run_cycles == 50);
      run_cycles++;
      @(negedge clk);
    end
    start = 1'b0;
    out_ready = 1'b0;
    chk(run_cycles < 40000, "R7", "done reached (watchdog)", run_cycles, 40000);
  endtask

  task automatic check_block(input string name);
    int dec = 0, sgc = 0, nz = 0, mis_ord = 0, mis_ctx = 0, first = -1;
    int n;
    build_model();
    for (int i = 0; i < 256; i++) if (mag[i] != 0) nz++;
    foreach (got_q[k]) if (got_q[k][4:1] == 4'd9) sgc++; else dec++;
    n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
    for (int k = 0; k < n; k++) begin
      if (got_q[k][6:5] != exp_q[k][6:5] || got_q[k][0] != exp_q[k][0]) begin
        mis_ord++;
        if (first < 0) first = k;
      end
      if (got_q[k][4:1] != exp_q[k][4:1]) mis_ctx++;
    end
    $display("block %s: pairs=%0d expected=%0d", name, got_q.size(), exp_q.size());
    chk(got_q.size() == exp_q.size(), "R2", {name, " pair count"}, got_q.size(), exp_q.size());
    chk(mis_ord == 0, "R2", {name, " pass/bit order mismatches"}, mis_ord, 0);
    chk(mis_ctx == 0, "R4", {name, " context mismatches"}, mis_ctx, 0);
    chk(dec == 2048, "R3", {name, " decision pairs (256 per plane)"}, dec, 2048);
    chk(sgc == nz, "R5", {name, " sign pairs vs non-zero samples"}, sgc, nz);
    chk(holds_bad == 0, "R6", {name, " output changed during stall"}, holds_bad, 0);
    repeat (3) @(negedge clk);
    chk(done == 1'b1 && out_valid == 1'b0, "R7", {name, " done held, stream quiet"},
        {done, out_valid}, 2);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(done == 1'b0, "R1", "done after reset", done, 0);
    rst_n = 1'b1;

    // all-zero block, full speed: skipping bound (R8)
    for (int i = 0; i < 256; i++) begin mag[i] = 8'd0; sgn[i] = 1'b0; end
    load_block();
    run_block(100, 1'b0);
    chk(run_cycles <= 2830, "R8", "cycles for all-zero block", run_cycles, 2830);
    check_block("zero");

    // single sample at row 5, column 2 (R9 index mapping)
    for (int i = 0; i < 256; i++) begin mag[i] = 8'd0; sgn[i] = 1'b0; end
    mag[5*16+2] = 8'h81;
    sgn[5*16+2] = 1'b1;
    load_block();
    run_block(100, 1'b0);
    check_block("single_R9");

    // sparse random, stalls
    for (int i = 0; i < 256; i++) begin
      mag[i] = (($urandom % 3) == 0) ? 8'($urandom) : 8'd0;
      sgn[i] = 1'($urandom);
    end
    load_block();
    run_block(70, 1'b0);
    check_block("sparse");

    // all maximum, alternating signs, heavy stalls
    for (int i = 0; i < 256; i++) begin mag[i] = 8'hFF; sgn[i] = 1'(i); end
    load_block();
    run_block(50, 1'b0);
    check_block("full_scale");

    // dense random with a start pulse mid-scan (R7: ignored)
    for (int i = 0; i < 256; i++) begin mag[i] = 8'($urandom); sgn[i] = 1'($urandom); end
    load_block();
    run_block(80, 1'b1);
    check_block("restart_ignored_R7");

    // checkerboard
    for (int i = 0; i < 256; i++) begin
      mag[i] = (((i / 16) + (i % 16)) % 2 == 1) ? 8'h55 : 8'h2A;
      sgn[i] = 1'((i / 16) % 2);
    end
    load_block();
    run_block(90, 1'b0);
    check_block("checker");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1900000;
    bad++;
    total++;
    $display("FAIL watchdog: run hung actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule